// File: doc/BRIEF.md
# Table-Driven Memory Controller Init Sequencer

This block brings a memory controller out of reset without software. On a start pulse it unlocks the register space with a key write and then polls until the lock register acknowledges. It writes the controller's first configuration word and polls that register for the same acknowledge. It reads the controller's layout configuration once. Then it replays a constant table of entries from a small registered ROM onto a simple register bus, one entry after another.

The ROM holds four kinds of entry. An ordinary write sends its data to the controller base plus its offset. A pause waits a number of 1 µs ticks. A patched write replaces its data according to the decoded memory layout and merges in two strap bits. A terminator ends the walk. After the walk the block reads the clock-setting register. It raises a one-cycle calibration request, carrying a bus-width flag, only when that register shows the calibrated-rate value. It then finishes with two read-modify-write fixups on system registers and holds `done_o` high.

The bus has one address port shared by reads and writes. A read is issued with `rd_en_o` for one cycle, and `rdata_i` must be valid in the following cycle. Calibration itself happens elsewhere.

Top module: `dram_init_seq`

## Requirements
- R1: After reset `done_o`, `wr_en_o`, `rd_en_o` and `cal_req_o` are all low, and nothing happens on the bus until `start_i` is seen.
- R2: The first write after start is key 0x5EC02D17 to address 0x0F000. Address 0x0F000 is then read repeatedly until it returns 0x1. The number of reads equals the number of non-acknowledge responses plus one, and no other write happens in between.
- R3: Next, word 0xC0DE0001 is written to the controller base 0x10000. That address is then polled the same way until it reads 0x1. After that, the layout register at 0x10004 is read once.
- R4: The layout decodes from layout register bits [3:2] and bit 6. Values 0 and 1 select 512Mx16. Value 2 selects 1Gx16 when bit 6 is 1 and 512Mx32 when bit 6 is 0. Value 3 selects 1Gx32 whatever bit 6 holds.
- R5: A patched entry writes 0xD89 for 1Gx16, 0xC8D for 1Gx32, and the entry's own data otherwise. The result is ORed with bits [3:2] of the strap register (0x0F070, read just before the write), placed at bits [3:2].
- R6: Ordinary entries write their data to 0x10000 plus their offset, in table order, repeats included. The default table is: write 0x008=0x00112233, write 0x010=0x44556677, pause 2, patched 0x040 (own data 0x481), write 0x028=5, write 0x028=7, write 0x028=3, write 0x00C=0x5A08, pause 1, write 0x034=0x7C03, write 0x120=0x5061, terminator.
- R7: A pause entry with count N holds the walk for N×15 ticks of `tick_us_i`. With the tick held low the walk stalls inside the pause.
- R8: The terminator ends the walk. No table write follows it, and the next bus access is a read of the clock-setting register at 0x10120.
- R9: `cal_req_o` pulses for exactly one cycle only when that read returns exactly 0x00005061. With the pulse, `cal_wide_o` is 1 (32-bit) when layout bit 6 was 0 and 0 (16-bit) when it was 1.
- R10: The last two writes are read-modify-writes. Address 0x0F00C gets its read value with bit 1 cleared, and then address 0x0F040 gets its read value with bit 6 set.
- R11: `done_o` rises after the last write and stays high until the next `start_i`, which clears it. A `start_i` during a run is ignored.
- R12: `wr_en_o` and `rd_en_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| wr_en_o | output | 1 | Register write strobe |
| rd_en_o | output | 1 | Register read strobe |
| addr_o | output | 20 | Register address for read or write |
| wdata_o | output | 32 | Write data |
| rdata_i | input | 32 | Read data, valid the cycle after `rd_en_o` |
| cal_req_o | output | 1 | One-cycle calibration request |
| cal_wide_o | output | 1 | Width with the request: 1 = 32-bit, 0 = 16-bit |
| done_o | output | 1 | Sequence complete, held until next start |

## Verification
The hardest states to reach from the ports are the two poll loops when the acknowledge is late, and a walk stopped in the middle of a pause. Both are visible only in timing and in read counts, not in the write trace. The bench's register model withholds the acknowledge for a chosen number of reads per vector and counts the polls. In a directed run it gates the microsecond tick off. This freezes the walk after the fourth write, and a second start pulse is injected there before the tick is released.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;

  typedef enum logic [1:0] {
    K_END   = 2'd0,
    K_WRITE = 2'd1,
    K_PAUSE = 2'd2,
    K_PATCH = 2'd3
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef enum logic [1:0] {
    LAY_512X16 = 2'd0,
    LAY_1GX16  = 2'd1,
    LAY_512X32 = 2'd2,
    LAY_1GX32  = 2'd3
  } layout_e;

  localparam logic [ADDR_W-1:0] LOCK_ADDR  = 20'h0F000;
  localparam logic [ADDR_W-1:0] STRAP_ADDR = 20'h0F070;
  localparam logic [ADDR_W-1:0] SYSA_ADDR  = 20'h0F00C;
  localparam logic [ADDR_W-1:0] SYSB_ADDR  = 20'h0F040;
  localparam logic [ADDR_W-1:0] MC_BASE    = 20'h10000;
  localparam logic [OFF_W-1:0]  CFG_OFF    = 12'h004;
  localparam logic [OFF_W-1:0]  CLK_OFF    = 12'h120;

  localparam logic [DATA_W-1:0] UNLOCK_KEY  = 32'h5EC0_2D17;
  localparam logic [DATA_W-1:0] MC_FIRST    = 32'hC0DE_0001;
  localparam logic [DATA_W-1:0] ACK_VAL     = 32'h0000_0001;
  localparam logic [DATA_W-1:0] CAL_CLK     = 32'h0000_5061;
  localparam logic [DATA_W-1:0] PATCH_1GX16 = 32'h0000_0D89;
  localparam logic [DATA_W-1:0] PATCH_1GX32 = 32'h0000_0C8D;

  function automatic logic [DATA_W-1:0] patch_data(layout_e lay,
                                                   logic [DATA_W-1:0] dflt,
                                                   logic [1:0] strap);
    logic [DATA_W-1:0] base;
    case (lay)
      LAY_1GX16: base = PATCH_1GX16;
      LAY_1GX32: base = PATCH_1GX32;
      default:   base = dflt;
    endcase
    return base | {{(DATA_W-4){1'b0}}, strap, 2'b00};
  endfunction
endpackage

// File: rtl/init_rom.sv
module init_rom import dinit_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  output entry_t           q
);
  function automatic entry_t rom_word(int unsigned i);
    case (i)
      0:  return '{kind: K_WRITE, off: 12'h008, data: 32'h0011_2233};
      1:  return '{kind: K_WRITE, off: 12'h010, data: 32'h4455_6677};
      2:  return '{kind: K_PAUSE, off: 12'h000, data: 32'd2};
      3:  return '{kind: K_PATCH, off: 12'h040, data: 32'h0000_0481};
      4:  return '{kind: K_WRITE, off: 12'h028, data: 32'h0000_0005};
      5:  return '{kind: K_WRITE, off: 12'h028, data: 32'h0000_0007};
      6:  return '{kind: K_WRITE, off: 12'h028, data: 32'h0000_0003};
      7:  return '{kind: K_WRITE, off: 12'h00C, data: 32'h0000_5A08};
      8:  return '{kind: K_PAUSE, off: 12'h000, data: 32'd1};
      9:  return '{kind: K_WRITE, off: 12'h034, data: 32'h0000_7C03};
      10: return '{kind: K_WRITE, off: 12'h120, data: 32'h0000_5061};
      default: return '{kind: K_END, off: '0, data: '0};
    endcase
  endfunction

  // registered read port, block-ROM style
  always_ff @(posedge clk) begin
    q <= rom_word(int'(idx));
  end
endmodule

// File: rtl/layout_decode.sv
module layout_decode import dinit_pkg::*; (
  input  logic [1:0] size_bits,
  input  logic       half_bit,
  output layout_e    lay
);
  always_comb begin
    case (size_bits)
      2'd2:    lay = half_bit ? LAY_1GX16 : LAY_512X32;
      2'd3:    lay = LAY_1GX32;
      default: lay = LAY_512X16;
    endcase
  end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int CNT_W  = 16,
  parameter int REPEAT = 15,
  localparam int REP_W = $clog2(REPEAT + 1),
  localparam int TOT_W = CNT_W + REP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  input  logic             tick,
  output logic             busy
);
  logic [TOT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (load) begin
      rem <= TOT_W'(count) * TOT_W'(REPEAT);
    end else if (tick && rem != '0) begin
      rem <= rem - 1'b1;
    end
  end

  assign busy = (rem != '0);
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq import dinit_pkg::*; #(
  parameter int ROM_DEPTH    = 16,
  parameter int PAUSE_W      = 16,
  parameter int PAUSE_REPEAT = 15,
  localparam int IDX_W = $clog2(ROM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_us_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              cal_req_o,
  output logic              cal_wide_o,
  output logic              done_o
);
  typedef enum logic [4:0] {
    S_IDLE, S_LK_W, S_LK_WT, S_LK_CHK, S_C0_W, S_C0_WT, S_C0_CHK,
    S_CF_WT, S_CF_CHK, S_FETCH, S_DECODE, S_PAUSE, S_PT_WT, S_PT_CHK,
    S_CK_WT, S_CK_CHK, S_A_WT, S_A_CHK, S_B_RD, S_B_WT, S_B_CHK, S_FIN
  } state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  entry_t           ent;
  logic [1:0]       size_q;
  logic             half_q;
  layout_e          lay;
  logic             tmr_load;
  logic             tmr_busy;

  init_rom #(.DEPTH(ROM_DEPTH)) u_rom (
    .clk (clk),
    .idx (idx),
    .q   (ent)
  );

  layout_decode u_lay (
    .size_bits (size_q),
    .half_bit  (half_q),
    .lay       (lay)
  );

  assign tmr_load = (state == S_DECODE) && (ent.kind == K_PAUSE);

  pause_timer #(.CNT_W(PAUSE_W), .REPEAT(PAUSE_REPEAT)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_load),
    .count (ent.data[PAUSE_W-1:0]),
    .tick  (tick_us_i),
    .busy  (tmr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      size_q     <= '0;
      half_q     <= 1'b0;
      wr_en_o    <= 1'b0;
      rd_en_o    <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
      cal_req_o  <= 1'b0;
      cal_wide_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      wr_en_o   <= 1'b0;
      rd_en_o   <= 1'b0;
      cal_req_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          done_o  <= 1'b0;
          wr_en_o <= 1'b1;
          addr_o  <= LOCK_ADDR;
          wdata_o <= UNLOCK_KEY;
          state   <= S_LK_W;
        end
        S_LK_W: begin
          rd_en_o <= 1'b1;
          addr_o  <= LOCK_ADDR;
          state   <= S_LK_WT;
        end
        S_LK_WT: state <= S_LK_CHK;
        S_LK_CHK: begin
          if (rdata_i == ACK_VAL) begin
            wr_en_o <= 1'b1;
            addr_o  <= MC_BASE;
            wdata_o <= MC_FIRST;
            state   <= S_C0_W;
          end else begin
            rd_en_o <= 1'b1;
            addr_o  <= LOCK_ADDR;
            state   <= S_LK_WT;
          end
        end
        S_C0_W: begin
          rd_en_o <= 1'b1;
          addr_o  <= MC_BASE;
          state   <= S_C0_WT;
        end
        S_C0_WT: state <= S_C0_CHK;
        S_C0_CHK: begin
          rd_en_o <= 1'b1;
          if (rdata_i == ACK_VAL) begin
            addr_o <= MC_BASE + ADDR_W'(CFG_OFF);
            state  <= S_CF_WT;
          end else begin
            addr_o <= MC_BASE;
            state  <= S_C0_WT;
          end
        end
        S_CF_WT: state <= S_CF_CHK;
        S_CF_CHK: begin
          size_q <= rdata_i[3:2];
          half_q <= rdata_i[6];
          idx    <= '0;
          state  <= S_FETCH;
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          case (ent.kind)
            K_WRITE: begin
              wr_en_o <= 1'b1;
              addr_o  <= MC_BASE + ADDR_W'(ent.off);
              wdata_o <= ent.data;
              idx     <= idx + 1'b1;
              state   <= S_FETCH;
            end
            K_PAUSE: state <= S_PAUSE;
            K_PATCH: begin
              rd_en_o <= 1'b1;
              addr_o  <= STRAP_ADDR;
              state   <= S_PT_WT;
            end
            default: begin
              rd_en_o <= 1'b1;
              addr_o  <= MC_BASE + ADDR_W'(CLK_OFF);
              state   <= S_CK_WT;
            end
          endcase
        end
        S_PAUSE: if (!tmr_busy) begin
          idx   <= idx + 1'b1;
          state <= S_FETCH;
        end
        S_PT_WT: state <= S_PT_CHK;
        S_PT_CHK: begin
          wr_en_o <= 1'b1;
          addr_o  <= MC_BASE + ADDR_W'(ent.off);
          wdata_o <= patch_data(lay, ent.data, rdata_i[3:2]);
          idx     <= idx + 1'b1;
          state   <= S_FETCH;
        end
        S_CK_WT: state <= S_CK_CHK;
        S_CK_CHK: begin
          if (rdata_i == CAL_CLK) begin
            cal_req_o  <= 1'b1;
            cal_wide_o <= ~half_q;
          end
          rd_en_o <= 1'b1;
          addr_o  <= SYSA_ADDR;
          state   <= S_A_WT;
        end
        S_A_WT: state <= S_A_CHK;
        S_A_CHK: begin
          wr_en_o <= 1'b1;
          addr_o  <= SYSA_ADDR;
          wdata_o <= rdata_i & ~32'h0000_0002;
          state   <= S_B_RD;
        end
        S_B_RD: begin
          rd_en_o <= 1'b1;
          addr_o  <= SYSB_ADDR;
          state   <= S_B_WT;
        end
        S_B_WT: state <= S_B_CHK;
        S_B_CHK: begin
          wr_en_o <= 1'b1;
          addr_o  <= SYSB_ADDR;
          wdata_o <= rdata_i | 32'h0000_0040;
          state   <= S_FIN;
        end
        S_FIN: begin
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk import dinit_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              wr_en_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic [DATA_W-1:0] rdata_i,
  input logic              cal_req_o,
  input logic              done_o
);
  p_bus_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && rd_en_o));

  p_cal_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    cal_req_o |=> !cal_req_o);

  p_cal_value_r9: assert property (@(posedge clk) disable iff (rst)
    cal_req_o |-> $past(rdata_i) == CAL_CLK);

  p_cal_addr_r8: assert property (@(posedge clk) disable iff (rst)
    cal_req_o |-> $past(rd_en_o, 2) && $past(addr_o, 2) == MC_BASE + ADDR_W'(CLK_OFF));

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !wr_en_o && !rd_en_o && !cal_req_o);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o);

  p_unlock_first_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(done_o) |-> wr_en_o && addr_o == LOCK_ADDR && wdata_o == UNLOCK_KEY);
endmodule

bind dram_init_seq dram_init_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .wr_en_o   (wr_en_o),
  .rd_en_o   (rd_en_o),
  .addr_o    (addr_o),
  .wdata_o   (wdata_o),
  .rdata_i   (rdata_i),
  .cal_req_o (cal_req_o),
  .done_o    (done_o)
);

// File: tb/dram_init_seq_bench.sv
`timescale 1ns/1ps
module dram_init_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        tick_us_i = 1'b0;
  logic        wr_en_o, rd_en_o, cal_req_o, cal_wide_o, done_o;
  logic [19:0] addr_o;
  logic [31:0] wdata_o;
  logic [31:0] rdata_i = '0;

  always #10 clk = ~clk;

  dram_init_seq u_dram_init_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_us_i(tick_us_i),
    .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .rdata_i(rdata_i), .cal_req_o(cal_req_o), .cal_wide_o(cal_wide_o),
    .done_o(done_o)
  );

  // vector table: layout cfg, strap, clock-register value, expected patch, cal, width
  localparam int NV = 7;
  localparam logic [7:0]  V_CFG   [NV] = '{8'h00, 8'h48, 8'h08, 8'h0C, 8'h4C, 8'h04, 8'h44};
  localparam logic [3:0]  V_STRAP [NV] = '{4'h0, 4'h4, 4'hC, 4'h8, 4'h3, 4'hF, 4'h0};
  localparam logic [31:0] V_CLK   [NV] = '{32'h5061, 32'h5061, 32'h5060, 32'h5061,
                                           32'h5061, 32'h15061, 32'h5061};
  localparam logic [31:0] V_PATCH [NV] = '{32'h481, 32'hD8D, 32'h48D, 32'hC8D,
                                           32'hC8D, 32'h48D, 32'h481};
  localparam logic        V_CAL   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        V_WIDE  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  int checks = 0, fails = 0;
  logic [31:0] cfg_val, strap_val, clk_val;
  int lock_delay, mc0_delay, lock_reads, mc0_reads;
  logic [19:0] t_addr [32];
  logic [31:0] t_data [32];
  int t_cyc [32];
  int nwr = 0, cyc = 0, cal_cnt = 0, bus_clash = 0, tdiv = 0;
  logic cal_w = 1'b0;
  bit tick_en = 1'b1;
  logic [19:0] e_addr [13];
  logic [31:0] e_data [13];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder, trace logger, tick source
  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % 4;
    tick_us_i = tick_en && (tdiv == 0);
    if (wr_en_o && rd_en_o) bus_clash++;
    if (wr_en_o && nwr < 32) begin
      t_addr[nwr] = addr_o; t_data[nwr] = wdata_o; t_cyc[nwr] = cyc; nwr++;
    end
    if (cal_req_o) begin cal_cnt++; cal_w = cal_wide_o; end
    if (rd_en_o) begin
      case (addr_o)
        20'h0F000: begin lock_reads++; rdata_i = (lock_reads > lock_delay) ? 32'h1 : 32'h0; end
        20'h10000: begin mc0_reads++;  rdata_i = (mc0_reads > mc0_delay) ? 32'h1 : 32'h2; end
        20'h10004: rdata_i = cfg_val;
        20'h0F070: rdata_i = strap_val;
        20'h10120: rdata_i = clk_val;
        20'h0F00C: rdata_i = 32'hA5A5_A5A7;
        20'h0F040: rdata_i = 32'h1234_5600;
        default:   rdata_i = 32'hDEAD_BEEF;
      endcase
    end
  end

  task automatic setup(input int v, input int ld, input int md);
    cfg_val = {24'h0, V_CFG[v]}; strap_val = {28'h0, V_STRAP[v]}; clk_val = V_CLK[v];
    lock_delay = ld; mc0_delay = md; lock_reads = 0; mc0_reads = 0;
    nwr = 0; cal_cnt = 0;
    e_addr[0] = 20'h0F000; e_data[0] = 32'h5EC0_2D17;
    e_addr[1] = 20'h10000; e_data[1] = 32'hC0DE_0001;
    e_addr[2] = 20'h10008; e_data[2] = 32'h0011_2233;
    e_addr[3] = 20'h10010; e_data[3] = 32'h4455_6677;
    e_addr[4] = 20'h10040; e_data[4] = V_PATCH[v];
    e_addr[5] = 20'h10028; e_data[5] = 32'h5;
    e_addr[6] = 20'h10028; e_data[6] = 32'h7;
    e_addr[7] = 20'h10028; e_data[7] = 32'h3;
    e_addr[8] = 20'h1000C; e_data[8] = 32'h5A08;
    e_addr[9] = 20'h10034; e_data[9] = 32'h7C03;
    e_addr[10] = 20'h10120; e_data[10] = 32'h5061;
    e_addr[11] = 20'h0F00C; e_data[11] = 32'hA5A5_A5A5;
    e_addr[12] = 20'h0F040; e_data[12] = 32'h1234_5640;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 6000) begin @(negedge clk); n++; end
    chk(req, 64'(done_o), 64'd1);
  endtask

  task automatic check_trace(input int v);
    chk("R6 R8 R10 write count", 64'(nwr), 64'd13);
    for (int k = 0; k < 13; k++) begin
      string tag;
      if (k == 0) tag = "R2 unlock write";
      else if (k == 1) tag = "R3 first config write";
      else if (k == 4) tag = "R4 R5 patched write";
      else if (k >= 11) tag = "R10 fixup write";
      else tag = "R6 table write";
      chk({tag, " addr"}, 64'(t_addr[k]), 64'(e_addr[k]));
      chk({tag, " data"}, 64'(t_data[k]), 64'(e_data[k]));
    end
    chk("R9 cal pulse count", 64'(cal_cnt), 64'(V_CAL[v]));
    if (V_CAL[v]) chk("R9 cal width", 64'(cal_w), 64'(V_WIDE[v]));
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setup(0, 0, 0);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done after reset", 64'(done_o), 64'd0);
    chk("R1 write idle", 64'(wr_en_o), 64'd0);
    chk("R1 read idle", 64'(rd_en_o), 64'd0);
    chk("R1 cal idle", 64'(cal_req_o), 64'd0);
    repeat (20) @(negedge clk);
    chk("R1 no bus activity before start", 64'(nwr), 64'd0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      setup(v, v % 3, (v + 1) % 2);
      pulse_start();
      chk("R11 done cleared by start", 64'(done_o), 64'd0);
      wait_done("R11 done reached");
      check_trace(v);
      chk("R2 lock poll count", 64'(lock_reads), 64'(lock_delay + 1));
      chk("R3 config poll count", 64'(mc0_reads), 64'(mc0_delay + 1));
      if (v == 0) begin
        // R7 pause spacing: 30 ticks then 15 ticks, 4 cycles per tick
        chk("R7 pause 2 spacing", 64'((t_cyc[4] - t_cyc[3]) >= 120 && (t_cyc[4] - t_cyc[3]) <= 132), 64'd1);
        chk("R7 pause 1 spacing", 64'((t_cyc[9] - t_cyc[8]) >= 60 && (t_cyc[9] - t_cyc[8]) <= 72), 64'd1);
      end
    end

    // R11 done holds while no start
    repeat (40) @(negedge clk);
    chk("R11 done held", 64'(done_o), 64'd1);
    chk("R11 no writes while done", 64'(nwr), 64'd13);

    // R7 stall with tick gated, R11 start ignored while busy
    setup(0, 2, 1);
    tick_en = 1'b0;
    pulse_start();
    repeat (400) @(negedge clk);
    chk("R7 walk stalled in pause", 64'(nwr), 64'd4);
    chk("R7 not done while stalled", 64'(done_o), 64'd0);
    pulse_start();
    repeat (10) @(negedge clk);
    tick_en = 1'b1;
    wait_done("R11 done after stall");
    check_trace(0);
    chk("R11 mid-run start ignored, lock polls", 64'(lock_reads), 64'd3);

    chk("R12 no read and write together", 64'(bus_clash), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule